// File: doc/BRIEF.md
# Command-Coded Interrupt Status and Vector Unit

This block keeps the interrupt status of one side of a peripheral: a bank of status registers, each holding two interrupt sources (one in the upper nibble, one in the lower nibble). Every source has three bits: pending, in-service and enable. Software never writes these bits directly. It writes a byte to a selected status register, and that byte carries one 3-bit command for the upper source and one for the lower source. Hardware event pulses can also set any pending bit at any time.

A fixed-priority scan over the registered status picks the winning source and turns it into a 3-bit interrupt code. When the master enable is on and the code is nonzero, the active-low interrupt output is driven low. A stored vector byte is returned on the vector read port. While the master enable is on, bits 3:1 of that byte are replaced by the current code, so one vector read tells software which source fired.

Top module: `isv_unit`

## Requirements
- R1: On a status write, bits 7:5 of `cmd_data` act on the upper source of the register chosen by `reg_sel`. The codes are: 001 clears in-service and pending, 010 sets in-service, 011 clears in-service, 100 sets pending, 101 clears pending, 110 sets enable, 111 clears enable.
- R2: Bits 3:1 of the same byte apply the same seven codes to the lower source. Code 000 leaves a source unchanged, bits 4 and 0 are ignored, and registers other than the selected one do not change.
- R3: A `hw_set` pulse sets its pending bit even when a clear command hits the same bit in the same cycle. Bit 2r of `hw_set` belongs to register r upper, and bit 2r+1 to register r lower.
- R4: A source requests service when it is pending, enabled and not in service. The scan order is reg0 upper, reg0 lower, reg1 upper, reg1 lower, and so on. The first requesting source sets the code. Both reg0 sources give code 7, and each later position gives one less (reg1 upper 6, down to reg3 lower 1). Code 0 means no request.
- R5: A source that is in service stops the scan at its position, so every source below it is masked, whatever its own pending bit shows.
- R6: `int_n` is high whenever `mie` was low at the previous clock edge. Otherwise it is low exactly when the code computed from the status is nonzero. It follows a status change with one cycle of delay.
- R7: With `mie` high, `vec_rdata` is the stored vector with bits 3:1 replaced by the registered code. With `mie` low, it is the stored vector unchanged. `vec_we` loads the stored vector.
- R8: `stat_rdata` shows the register chosen by `reg_sel` as {P,S,E,0} for the upper source in bits 7:4 and {P,S,E,0} for the lower source in bits 3:0. Here P is pending, S is in-service and E is enable.
- R9: After reset all status bits and the vector are zero, and `int_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mie | input | 1 | Master interrupt enable |
| reg_sel | input | 2 | Status register index for writes and for `stat_rdata` |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte (upper code 7:5, lower code 3:1) |
| vec_we | input | 1 | Vector load strobe |
| vec_wdata | input | 8 | Vector value to store |
| hw_set | input | 8 | Hardware pending-set pulses, one per source |
| stat_rdata | output | 8 | Selected status register |
| vec_rdata | output | 8 | Vector read value |
| int_n | output | 1 | Active-low interrupt request |

## Verification
A wrong status bit in any source shows up on `stat_rdata` as soon as the write edge has passed. It also moves `vec_rdata` bits 3:1 and `int_n` one cycle later. If the priority scan is wrong, the code is wrong or a masked source leaks through within two edges of the command. The bench therefore walks every command pair across every register, mixes in hardware pulses and master-enable changes, and after each step compares all four status bytes, the vector and the interrupt pin against an arithmetic model.

// File: rtl/isv_pkg.sv
package isv_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_CLR_BOTH = 3'd1,
    CMD_SET_SVC  = 3'd2,
    CMD_CLR_SVC  = 3'd3,
    CMD_SET_PEND = 3'd4,
    CMD_CLR_PEND = 3'd5,
    CMD_SET_EN   = 3'd6,
    CMD_CLR_EN   = 3'd7
  } isv_cmd_e;

  // Code of a scan position: first pair shares the top code, then one less per step.
  function automatic logic [CODE_W-1:0] pos_code(input int pos);
    int c;
    c = (pos == 0) ? 7 : 8 - pos;
    if (c < 0) c = 0;
    return c[CODE_W-1:0];
  endfunction

endpackage

// File: rtl/isv_source.sv
module isv_source
  import isv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_valid,
  input  isv_cmd_e cmd,
  input  logic     hw_set,
  output logic     pend,
  output logic     insvc,
  output logic     enab
);

  logic pend_n, insvc_n, enab_n;

  always_comb begin
    pend_n  = pend;
    insvc_n = insvc;
    enab_n  = enab;
    if (cmd_valid) begin
      case (cmd)
        CMD_CLR_BOTH: begin insvc_n = 1'b0; pend_n = 1'b0; end
        CMD_SET_SVC:  insvc_n = 1'b1;
        CMD_CLR_SVC:  insvc_n = 1'b0;
        CMD_SET_PEND: pend_n  = 1'b1;
        CMD_CLR_PEND: pend_n  = 1'b0;
        CMD_SET_EN:   enab_n  = 1'b1;
        CMD_CLR_EN:   enab_n  = 1'b0;
        default:      ;
      endcase
    end
    // hardware event has the last word on the pending bit
    if (hw_set) pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      insvc <= 1'b0;
      enab  <= 1'b0;
    end else begin
      pend  <= pend_n;
      insvc <= insvc_n;
      enab  <= enab_n;
    end
  end

  assert_hw_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> pend);

  assert_set_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_SET_EN) |=> enab);

  assert_clear_both_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_CLR_BOTH && !hw_set) |=> (!pend && !insvc));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((!cmd_valid || cmd == CMD_NOP) && !hw_set) |=> $stable({pend, insvc, enab}));

endmodule

// File: rtl/isv_priority.sv
module isv_priority
  import isv_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] insvc,
  input  logic [NUM_SRC-1:0] enab,
  output logic [CODE_W-1:0]  code
);

  logic [NUM_SRC-1:0] req;

  assign req = pend & enab & ~insvc;

  always_comb begin
    logic stop;
    stop = 1'b0;
    code = '0;
    for (int p = 0; p < NUM_SRC; p++) begin
      if (!stop) begin
        if (insvc[p]) begin
          stop = 1'b1;
        end else if (req[p]) begin
          code = pos_code(p);
          stop = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/isv_vector.sv
module isv_vector
  import isv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mie,
  input  logic              vec_we,
  input  logic [DATA_W-1:0] vec_wdata,
  input  logic [CODE_W-1:0] code_in,
  output logic [DATA_W-1:0] vec_rdata,
  output logic              int_n
);

  logic [DATA_W-1:0] vec_q, vec_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic              irq_q, irq_n;

  always_comb begin
    vec_n  = vec_we ? vec_wdata : vec_q;
    code_n = code_in;
    irq_n  = mie && (code_in != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      code_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      vec_q  <= vec_n;
      code_q <= code_n;
      irq_q  <= irq_n;
    end
  end

  always_comb begin
    vec_rdata = vec_q;
    if (mie) vec_rdata[CODE_W:1] = code_q;
  end

  assign int_n = ~irq_q;

  assert_mie_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mie |=> int_n);

  assert_vec_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mie && !int_n) |-> (vec_rdata[CODE_W:1] != '0));

endmodule

// File: rtl/isv_unit.sv
module isv_unit
  import isv_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8,
  parameter int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mie,
  input  logic [SEL_W-1:0]      reg_sel,
  input  logic                  cmd_we,
  input  logic [DATA_W-1:0]     cmd_data,
  input  logic                  vec_we,
  input  logic [DATA_W-1:0]     vec_wdata,
  input  logic [2*NUM_REGS-1:0] hw_set,
  output logic [DATA_W-1:0]     stat_rdata,
  output logic [DATA_W-1:0]     vec_rdata,
  output logic                  int_n
);

  localparam int NUM_SRC = 2 * NUM_REGS;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic [NUM_SRC-1:0] pend, insvc, enab;
  logic [CODE_W-1:0]  prio_code;
  isv_cmd_e           cmd_hi, cmd_lo;
  logic               unused_cmd_bits;

  assign cmd_hi          = isv_cmd_e'(cmd_data[7:5]);
  assign cmd_lo          = isv_cmd_e'(cmd_data[3:1]);
  assign unused_cmd_bits = ^{cmd_data[4], cmd_data[0]};

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit;
    assign hit = cmd_we && (reg_sel == SEL_W'(r));

    isv_source u_hi (
      .clk(clk), .rst_n(rst_sync_n), .cmd_valid(hit), .cmd(cmd_hi),
      .hw_set(hw_set[2*r]), .pend(pend[2*r]), .insvc(insvc[2*r]), .enab(enab[2*r])
    );

    isv_source u_lo (
      .clk(clk), .rst_n(rst_sync_n), .cmd_valid(hit), .cmd(cmd_lo),
      .hw_set(hw_set[2*r+1]), .pend(pend[2*r+1]), .insvc(insvc[2*r+1]), .enab(enab[2*r+1])
    );
  end

  always_comb begin
    stat_rdata = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (reg_sel == SEL_W'(r))
        stat_rdata = {pend[2*r], insvc[2*r], enab[2*r], 1'b0,
                      pend[2*r+1], insvc[2*r+1], enab[2*r+1], 1'b0};
    end
  end

  isv_priority #(.NUM_SRC(NUM_SRC)) u_prio (
    .pend(pend), .insvc(insvc), .enab(enab), .code(prio_code)
  );

  isv_vector #(.DATA_W(DATA_W)) u_vec (
    .clk(clk), .rst_n(rst_sync_n), .mie(mie), .vec_we(vec_we),
    .vec_wdata(vec_wdata), .code_in(prio_code), .vec_rdata(vec_rdata), .int_n(int_n)
  );

  assert_request_has_code_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !int_n |-> ($past(prio_code) != '0));

  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(rst_sync_n) || $past(!rst_sync_n)) |-> int_n);

endmodule

// File: tb/sim_isv_unit.sv
module sim_isv_unit;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, mie, cmd_we, vec_we;
  logic [1:0] reg_sel;
  logic [7:0] cmd_data, vec_wdata, hw_set;
  logic [7:0] stat_rdata, vec_rdata;
  logic       int_n;

  int checks = 0;
  int errors = 0;

  bit       mp[8], ms[8], me[8];
  bit [7:0] vm;

  always #(CLK_PERIOD/2) clk = ~clk;

  isv_unit u0 (
    .clk(clk), .rst_n(rst_n), .mie(mie), .reg_sel(reg_sel), .cmd_we(cmd_we),
    .cmd_data(cmd_data), .vec_we(vec_we), .vec_wdata(vec_wdata), .hw_set(hw_set),
    .stat_rdata(stat_rdata), .vec_rdata(vec_rdata), .int_n(int_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic model_cmd(input int p, input bit [2:0] c);
    case (c)
      3'd1: begin ms[p] = 0; mp[p] = 0; end
      3'd2: ms[p] = 1;
      3'd3: ms[p] = 0;
      3'd4: mp[p] = 1;
      3'd5: mp[p] = 0;
      3'd6: me[p] = 1;
      3'd7: me[p] = 0;
      default: ;
    endcase
  endtask

  function automatic int exp_code();
    for (int p = 0; p < 8; p++) begin
      if (ms[p]) return 0;
      if (mp[p] && me[p]) return (p == 0) ? 7 : 8 - p;
    end
    return 0;
  endfunction

  function automatic bit [7:0] exp_stat(input int r);
    return {mp[2*r], ms[2*r], me[2*r], 1'b0, mp[2*r+1], ms[2*r+1], me[2*r+1], 1'b0};
  endfunction

  // one write cycle; returns at the falling edge after the capturing edge
  task automatic drive(input bit we, input int sel, input bit [7:0] d, input bit [7:0] hw,
                       input bit vwe, input bit [7:0] vd, input bit m);
    @(negedge clk);
    cmd_we = we; reg_sel = sel[1:0]; cmd_data = d; hw_set = hw;
    vec_we = vwe; vec_wdata = vd; mie = m;
    if (we) begin
      model_cmd(2*sel, d[7:5]);
      model_cmd(2*sel+1, d[3:1]);
    end
    for (int p = 0; p < 8; p++) if (hw[p]) mp[p] = 1;
    if (vwe) vm = vd;
    @(negedge clk);
    cmd_we = 0; hw_set = 0; vec_we = 0;
  endtask

  task automatic check_model(input bit m);
    bit [7:0] ev;
    int       c;
    for (int r = 0; r < 4; r++) begin
      reg_sel = r[1:0];
      #1;
      chk(stat_rdata == exp_stat(r), "R1/R2/R3/R8 status", stat_rdata, exp_stat(r));
    end
    c  = exp_code();
    ev = vm;
    if (m) ev[3:1] = c[2:0];
    chk(vec_rdata == ev, "R4/R5/R7 vector", vec_rdata, ev);
    chk(int_n == !(m && c != 0), "R6 int_n", int_n, !(m && c != 0));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; mie = 0; cmd_we = 0; vec_we = 0; reg_sel = 0;
    cmd_data = 0; vec_wdata = 0; hw_set = 0; vm = 0;
    for (int p = 0; p < 8; p++) begin mp[p] = 0; ms[p] = 0; me[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R9 reset state
    chk(int_n == 1'b1, "R9 int_n", int_n, 1);
    chk(vec_rdata == 8'h00, "R9 vector", vec_rdata, 0);
    for (int r = 0; r < 4; r++) begin
      reg_sel = r[1:0]; #1;
      chk(stat_rdata == 8'h00, "R9 status", stat_rdata, 0);
    end

    // R1/R6: reg1 upper enable then pending; pin lags by one edge
    drive(1, 1, 8'hC0, 0, 0, 0, 1);
    drive(1, 1, 8'h80, 0, 0, 0, 1);
    reg_sel = 1; #1;
    chk(stat_rdata == 8'hA0, "R1 set enable+pending", stat_rdata, 8'hA0);
    chk(int_n == 1'b1, "R6 one-cycle lag", int_n, 1);
    @(negedge clk);
    chk(int_n == 1'b0, "R6 request asserted", int_n, 0);
    chk(vec_rdata == 8'h0C, "R4/R7 code 6", vec_rdata, 8'h0C);

    // R5: reg0 lower in service masks reg1 upper
    drive(1, 0, 8'h04, 0, 0, 0, 1);
    @(negedge clk);
    chk(int_n == 1'b1, "R5 masked by in-service", int_n, 1);
    chk(vec_rdata == 8'h00, "R5 code 0", vec_rdata, 0);
    drive(1, 0, 8'h06, 0, 0, 0, 1);
    @(negedge clk);
    chk(vec_rdata == 8'h0C, "R5 unmasked again", vec_rdata, 8'h0C);

    // R3: clear pending collides with hardware set
    drive(1, 1, 8'hA0, 8'h04, 0, 0, 1);
    reg_sel = 1; #1;
    chk(stat_rdata == 8'hA0, "R3 set wins", stat_rdata, 8'hA0);

    // R2: no-op codes with bits 4 and 0 set
    drive(1, 1, 8'h11, 0, 0, 0, 1);
    reg_sel = 1; #1;
    chk(stat_rdata == 8'hA0, "R2 no-op", stat_rdata, 8'hA0);

    // R7: vector merge on and off
    drive(0, 0, 0, 0, 1, 8'hF3, 1);
    @(negedge clk);
    chk(vec_rdata == 8'hFD, "R7 merged vector", vec_rdata, 8'hFD);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk(vec_rdata == 8'hF3, "R7 raw vector", vec_rdata, 8'hF3);
    chk(int_n == 1'b1, "R6 mie off", int_n, 1);

    // sweep every command pair over every register
    for (int s = 0; s < 256; s++) begin
      bit [7:0] d, hw, vd;
      bit       m;
      d  = {s[2:0], s[0] ^ s[3], s[5:3], s[1]};
      hw = (s % 5 == 0) ? 8'((s * 29) & 255) : 8'h00;
      vd = 8'(s) ^ 8'h5A;
      m  = (s % 7) != 3;
      drive(1, (s / 64) % 4, d, hw, (s % 16) == 0, vd, m);
      @(negedge clk);
      check_model(m);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule